// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This block sits beside a program sequencer and runs a body of instructions repeatedly without any branch instruction in the body. A loop-start command arrives while the start instruction is being fetched. It carries the address of the last instruction of the body, a mode, and either a pass count or nothing. In the condition mode the loop ends on an external flag. The controller records the address just after the start instruction as the loop top.

On every valid fetch the controller compares the current program counter with the stored end address. At a match it tells the sequencer to take the loop top as the next PC instead of PC+1, until the loop ends. Loops can nest up to a parameterised depth. A small stack keeps the top, end, count and mode of each enclosing loop and restores them when an inner loop finishes.

All outputs are combinational from the current fetch and the registered loop state, so the sequencer uses them in the same cycle. Every pin is plain control: there is no streamed data and no back-pressure.

Top module: `hw_loop_ctrl`

## Requirements
- R1: After reset, `active_o`, `redirect_o` and `error_o` are 0 and `target_o` equals `pc_i`+1.
- R2: When `start_i` is 1, the new loop's top is `pc_i`+1, and `active_o` is 1 from the next cycle.
- R3: During a valid fetch at the stored end address, with the loop not ending, `redirect_o` is 1 and `target_o` is the loop top. At any other address, `redirect_o` is 0 and `target_o` is `pc_i`+1.
- R4: In count mode (`mode_i`=0), a count N from 1 to 255 gives N passes through the end address. The first N-1 passes redirect and the Nth falls through to end+1. A count of 0 gives 256 passes.
- R5: In condition mode (`mode_i`=1), the loop falls through at an end-address fetch when `cond_i` is 1 and redirects when it is 0. `cond_i` has no effect at any other address.
- R6: When the only loop falls through at its end address, `active_o` is 0 in that same cycle.
- R7: A start while a loop is active nests a new loop. When the inner loop finishes, the outer loop's top, end, remaining count and mode are in force again.
- R8: A start when DEPTH loops are already active is ignored. `error_o` then goes to 1 and stays 1 until reset.
- R9: A loop whose end address is the start address +1 repeats that single instruction for the given count, up to 256 times.
- R10: When `fetch_vld_i` is 0, there is no redirect and the pass count does not change.
- R11: In a cycle with `start_i` at 1, no end-address comparison is made and `redirect_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_vld_i | input | 1 | A fetch at `pc_i` takes place this cycle |
| pc_i | input | AW | Address of the instruction being fetched |
| start_i | input | 1 | Loop-start command, given with the start instruction's fetch |
| end_addr_i | input | AW | Address of the last instruction of the new loop body |
| count_i | input | CW | Pass count for count mode; 0 means 2^CW |
| mode_i | input | 1 | 0 = count mode, 1 = condition mode |
| cond_i | input | 1 | Termination flag for condition mode |
| redirect_o | output | 1 | Next-PC select: 1 = loop top, 0 = PC+1 |
| target_o | output | AW | Next PC selected by the controller |
| active_o | output | 1 | At least one loop stays in force after this fetch |
| error_o | output | 1 | Sticky loop-stack overflow flag |

## Verification
Count-mode loops are run from a table with several body lengths and counts. The table includes a count of 1, a count of 0 (256 passes), a count of 255 and a one-instruction body. Together these separate an off-by-one in the pass counter from an error in the end compare or the top capture. Condition-mode runs raise the flag away from the end address and then at it, which shows that only end-address fetches can terminate the loop. A two-level nest, a stack filled past its depth, fetches with the valid bit low, and a start placed on an outer loop's end address check the restore path, the overflow flag and the two cases where the compare must not act.

// File: rtl/hwl_pkg.sv
`timescale 1ns/1ps
package hwl_pkg;
  typedef enum logic {
    LM_COUNT = 1'b0,
    LM_COND  = 1'b1
  } loop_mode_e;
endpackage

// File: rtl/hwl_stack.sv
`timescale 1ns/1ps
module hwl_stack #(
  parameter int AW    = 16,
  parameter int CW    = 8,
  parameter int DEPTH = 4,
  localparam int DW   = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push,
  input  logic                pop,
  input  logic                upd_cnt,
  input  logic [AW-1:0]       push_top,
  input  logic [AW-1:0]       push_end,
  input  logic [CW-1:0]       push_cnt,
  input  hwl_pkg::loop_mode_e push_mode,
  input  logic [CW-1:0]       new_cnt,
  output logic [AW-1:0]       cur_top,
  output logic [AW-1:0]       cur_end,
  output logic [CW-1:0]       cur_cnt,
  output hwl_pkg::loop_mode_e cur_mode,
  output logic [DW-1:0]       depth,
  output logic                full,
  output logic                loaded
);
  logic [AW-1:0]       top_q  [DEPTH];
  logic [AW-1:0]       end_q  [DEPTH];
  logic [CW-1:0]       cnt_q  [DEPTH];
  hwl_pkg::loop_mode_e mode_q [DEPTH];
  logic [DW-1:0]       depth_q;
  logic [DW-1:0]       idx_w;
  logic [IW-1:0]       idx;

  assign loaded = (depth_q != '0);
  assign full   = (depth_q == DW'(DEPTH));
  assign depth  = depth_q;
  assign idx_w  = depth_q - DW'(1);
  assign idx    = idx_w[IW-1:0];

  always_comb begin
    if (loaded) begin
      cur_top  = top_q[idx];
      cur_end  = end_q[idx];
      cur_cnt  = cnt_q[idx];
      cur_mode = mode_q[idx];
    end else begin
      cur_top  = '0;
      cur_end  = '0;
      cur_cnt  = '0;
      cur_mode = hwl_pkg::LM_COUNT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                depth_q <= '0;
    else if (push && !full)    depth_q <= depth_q + DW'(1);
    else if (pop && loaded)    depth_q <= depth_q - DW'(1);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic wr_new, wr_cnt;
    assign wr_new = push && (depth_q == DW'(i));
    assign wr_cnt = upd_cnt && (depth_q == DW'(i + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        top_q[i]  <= '0;
        end_q[i]  <= '0;
        cnt_q[i]  <= '0;
        mode_q[i] <= hwl_pkg::LM_COUNT;
      end else if (wr_new) begin
        top_q[i]  <= push_top;
        end_q[i]  <= push_end;
        cnt_q[i]  <= push_cnt;
        mode_q[i] <= push_mode;
      end else if (wr_cnt) begin
        cnt_q[i]  <= new_cnt;
      end
    end
  end

  // R7: depth never exceeds the stack size
  a_r7_depth_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    depth_q <= DW'(DEPTH));
  // R4: a count update lands on the entry in force
  a_r4_count_written: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_cnt && !push && !pop) |=> (cur_cnt == $past(new_cnt)));
endmodule

// File: rtl/hwl_eval.sv
`timescale 1ns/1ps
module hwl_eval #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic                fetch_vld,
  input  logic                start,
  input  logic                cond,
  input  logic                loaded,
  input  logic [AW-1:0]       pc,
  input  logic [AW-1:0]       cur_end,
  input  logic [CW-1:0]       cur_cnt,
  input  hwl_pkg::loop_mode_e cur_mode,
  output logic                leave,
  output logic                again,
  output logic                upd_cnt,
  output logic [CW-1:0]       cnt_dec
);
  logic at_end, done;

  assign at_end  = loaded && fetch_vld && !start && (pc == cur_end);
  assign done    = (cur_mode == hwl_pkg::LM_COND) ? cond : (cur_cnt == CW'(1));
  assign leave   = at_end && done;
  assign again   = at_end && !done;
  assign upd_cnt = again && (cur_mode == hwl_pkg::LM_COUNT);
  assign cnt_dec = cur_cnt - CW'(1);
endmodule

// File: rtl/hw_loop_ctrl.sv
`timescale 1ns/1ps
module hw_loop_ctrl #(
  parameter int AW    = 16,
  parameter int CW    = 8,
  parameter int DEPTH = 4,
  localparam int DW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_vld_i,
  input  logic [AW-1:0] pc_i,
  input  logic          start_i,
  input  logic [AW-1:0] end_addr_i,
  input  logic [CW-1:0] count_i,
  input  logic          mode_i,
  input  logic          cond_i,
  output logic          redirect_o,
  output logic [AW-1:0] target_o,
  output logic          active_o,
  output logic          error_o
);
  logic [AW-1:0]       cur_top, cur_end;
  logic [CW-1:0]       cur_cnt, cnt_dec;
  hwl_pkg::loop_mode_e cur_mode;
  logic [DW-1:0]       depth;
  logic                full, loaded, leave, again, upd_cnt, err_q;
  logic [AW-1:0]       pc_inc;

  assign pc_inc = pc_i + AW'(1);

  hwl_stack #(.AW(AW), .CW(CW), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n),
    .push(start_i), .pop(leave), .upd_cnt(upd_cnt),
    .push_top(pc_inc), .push_end(end_addr_i), .push_cnt(count_i),
    .push_mode(hwl_pkg::loop_mode_e'(mode_i)), .new_cnt(cnt_dec),
    .cur_top(cur_top), .cur_end(cur_end), .cur_cnt(cur_cnt), .cur_mode(cur_mode),
    .depth(depth), .full(full), .loaded(loaded)
  );

  hwl_eval #(.AW(AW), .CW(CW)) u_eval (
    .fetch_vld(fetch_vld_i), .start(start_i), .cond(cond_i), .loaded(loaded),
    .pc(pc_i), .cur_end(cur_end), .cur_cnt(cur_cnt), .cur_mode(cur_mode),
    .leave(leave), .again(again), .upd_cnt(upd_cnt), .cnt_dec(cnt_dec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                err_q <= 1'b0;
    else if (start_i && full)  err_q <= 1'b1;
  end

  assign redirect_o = again;
  assign target_o   = again ? cur_top : pc_inc;
  assign active_o   = loaded && !(leave && depth == DW'(1));
  assign error_o    = err_q;

  // R3: a redirect only happens while a loop is in force
  a_r3_redirect_in_loop: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> active_o);
  // R8: the overflow flag holds once raised
  a_r8_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |=> error_o);
  // R6: a fall-through pops exactly one level
  a_r6_exit_pops: assert property (@(posedge clk) disable iff (!rst_n)
    leave |=> (depth == $past(depth) - DW'(1)));
  // R11: the start cycle never redirects
  a_r11_start_no_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !redirect_o);
  // R10: without a fetch the pass state is left alone
  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_vld_i && !start_i) |=> $stable(cur_cnt) && $stable(depth));
endmodule

// File: tb/hw_loop_ctrl_bench.sv
`timescale 1ns/1ps
module hw_loop_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_vld_i, start_i, mode_i, cond_i;
  logic [15:0] pc_i, end_addr_i, target_o;
  logic [7:0]  count_i;
  logic        redirect_o, active_o, error_o;
  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  hw_loop_ctrl #(.AW(16), .CW(8), .DEPTH(4)) u_hw_loop_ctrl (
    .clk(clk), .rst_n(rst_n), .fetch_vld_i(fetch_vld_i), .pc_i(pc_i),
    .start_i(start_i), .end_addr_i(end_addr_i), .count_i(count_i),
    .mode_i(mode_i), .cond_i(cond_i), .redirect_o(redirect_o),
    .target_o(target_o), .active_o(active_o), .error_o(error_o)
  );

  // {start address, body length, count}
  localparam logic [31:0] VEC [6] = '{
    {16'h0010, 8'd3, 8'd5},
    {16'h0040, 8'd1, 8'd4},
    {16'h0080, 8'd2, 8'd1},
    {16'h0100, 8'd1, 8'd0},
    {16'h0200, 8'd5, 8'd2},
    {16'h0300, 8'd2, 8'd255}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic vld, input logic [15:0] pc, input logic st,
                       input logic [15:0] e, input logic [7:0] c, input logic md, input logic cd);
    @(negedge clk);
    fetch_vld_i = vld; pc_i = pc; start_i = st; end_addr_i = e;
    count_i = c; mode_i = md; cond_i = cd;
    #1;
  endtask

  task automatic fetch(input logic [15:0] pc, input logic cd);
    drive(1'b1, pc, 1'b0, 16'h0, 8'h0, 1'b0, cd);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    fetch_vld_i = 0; pc_i = 0; start_i = 0; end_addr_i = 0; count_i = 0; mode_i = 0; cond_i = 0;
    #3 rst_n = 1'b1;
  endtask

  task automatic run_vec(input logic [15:0] s, input logic [7:0] len, input logic [7:0] c, input string tag);
    int passes = 0, total, bad = 0;
    bit done = 1'b0;
    logic [15:0] pc, e, exp_t;
    logic exp_r, last;
    total = (c == 0) ? 256 : int'(c);
    e = s + 16'(len);
    drive(1'b1, s, 1'b1, e, c, 1'b0, 1'b0);
    pc = s + 16'd1;
    while (!done) begin
      fetch(pc, 1'b0);
      exp_r = (pc == e) && (passes + 1 < total);
      last  = (pc == e) && (passes + 1 == total);
      exp_t = exp_r ? s + 16'd1 : pc + 16'd1;
      if (redirect_o !== exp_r || target_o !== exp_t || active_o !== !last) begin
        if (bad == 0) $display("FAIL %s at pc=%0h actual=%0h expected=%0h", tag, pc, target_o, exp_t);
        bad++;
      end
      if (pc == e) passes++;
      if (last) done = 1'b1;
      pc = exp_t;
    end
    fetch(pc, 1'b0);
    if (active_o !== 1'b0) bad++;
    checks++;
    if (bad != 0) failures++;
  endtask

  initial begin
    do_reset();
    // R1: reset state
    fetch(16'h0123, 1'b0);
    chk(active_o == 0 && redirect_o == 0 && error_o == 0, "R1 idle flags", {active_o, redirect_o, error_o}, 0);
    chk(target_o == 16'h0124, "R1 target", target_o, 16'h0124);

    // table-driven count-mode loops (R3 R4 R6 R9)
    for (int i = 0; i < 6; i++) begin
      do_reset();
      run_vec(VEC[i][31:16], VEC[i][15:8], VEC[i][7:0],
              VEC[i][15:8] == 1 ? "R9 R4 single-instruction" : "R3 R4 R6 count loop");
    end

    // R2: top captured as start+1, active from next cycle
    do_reset();
    drive(1'b1, 16'h0400, 1'b1, 16'h0402, 8'd3, 1'b0, 1'b0);
    chk(active_o == 0, "R2 not active in start cycle", active_o, 0);
    fetch(16'h0401, 1'b0);
    chk(active_o == 1, "R2 active after start", active_o, 1);
    fetch(16'h0402, 1'b0);
    chk(redirect_o && target_o == 16'h0401, "R2 R3 top is start+1", target_o, 16'h0401);
    // R11: start on the outer end address does not compare
    drive(1'b1, 16'h0402, 1'b1, 16'h0404, 8'd1, 1'b0, 1'b0);
    chk(!redirect_o && target_o == 16'h0403, "R11 start cycle", target_o, 16'h0403);

    // R5: condition mode
    do_reset();
    drive(1'b1, 16'h0600, 1'b1, 16'h0602, 8'd0, 1'b1, 1'b0);
    fetch(16'h0601, 1'b1);
    chk(!redirect_o && active_o && target_o == 16'h0602, "R5 cond ignored off end", target_o, 16'h0602);
    fetch(16'h0602, 1'b0);
    chk(redirect_o && target_o == 16'h0601, "R5 cond low repeats", target_o, 16'h0601);
    fetch(16'h0601, 1'b0);
    fetch(16'h0602, 1'b1);
    chk(!redirect_o && !active_o && target_o == 16'h0603, "R5 R6 cond high exits", target_o, 16'h0603);

    // R10: no fetch, no redirect, no count change
    do_reset();
    drive(1'b1, 16'h0700, 1'b1, 16'h0701, 8'd2, 1'b0, 1'b0);
    drive(1'b0, 16'h0701, 1'b0, 16'h0, 8'h0, 1'b0, 1'b0);
    chk(!redirect_o, "R10 no redirect without fetch", redirect_o, 0);
    fetch(16'h0701, 1'b0);
    chk(redirect_o, "R10 count unchanged first pass", redirect_o, 1);
    fetch(16'h0701, 1'b0);
    chk(!redirect_o && !active_o, "R10 exits on second pass", redirect_o, 0);

    // R7: nesting restores the outer loop
    do_reset();
    drive(1'b1, 16'h0500, 1'b1, 16'h0506, 8'd2, 1'b0, 1'b0);
    fetch(16'h0501, 1'b0);
    drive(1'b1, 16'h0502, 1'b1, 16'h0504, 8'd2, 1'b0, 1'b0);
    fetch(16'h0503, 1'b0);
    fetch(16'h0504, 1'b0);
    chk(redirect_o && target_o == 16'h0503, "R7 inner repeats", target_o, 16'h0503);
    fetch(16'h0503, 1'b0);
    fetch(16'h0504, 1'b0);
    chk(!redirect_o && active_o, "R7 inner exit keeps outer", {redirect_o, active_o}, 1);
    fetch(16'h0505, 1'b0);
    fetch(16'h0506, 1'b0);
    chk(redirect_o && target_o == 16'h0501, "R7 outer restored", target_o, 16'h0501);

    // R8: overflow
    do_reset();
    for (int k = 0; k < 4; k++)
      drive(1'b1, 16'h0900 + 16'(k * 16), 1'b1, 16'h0908 + 16'(k * 16), 8'd3, 1'b0, 1'b0);
    fetch(16'h0931, 1'b0);
    chk(error_o == 0, "R8 full stack no error", error_o, 0);
    drive(1'b1, 16'h0932, 1'b1, 16'h0934, 8'd3, 1'b0, 1'b0);
    fetch(16'h0938, 1'b0);
    chk(error_o == 1, "R8 overflow raises error", error_o, 1);
    chk(redirect_o && target_o == 16'h0931, "R8 fifth start ignored", target_o, 16'h0931);
    fetch(16'h0939, 1'b0);
    chk(error_o == 1, "R8 error sticky", error_o, 1);
    do_reset();
    fetch(16'h0000, 1'b0);
    chk(error_o == 0, "R8 R1 reset clears error", error_o, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule